// File: doc/BRIEF.md
# Processor Bus Register Slave with Access Watchdog

This block sits between an external microprocessor and the internal register space of a chip. The processor presents a 13-bit address, a 16-bit write data word with two parity bits, a read/write select and an active-low chip select. The slave captures each access and forwards it to an internal register port. It then waits for that port's acknowledgment and returns a one-clock active-low acknowledge to the processor. On reads it also returns the read data and its generated parity.

Two faults end an access with a one-clock active-low transfer error pulse instead of the normal acknowledge. The first is an internal port that gives no acknowledgment within a bounded window of clocks. The second is write data whose parity does not match the data. A two-bit mode input chooses how the chip select is sampled: directly, or through a synchronizer when the processor bus runs asynchronously to the block clock. One mode value suppresses the parity error path. All logic runs on the processor clock.

Top module: `pbus_slave`

## Requirements
- R1: While reset is asserted and after its release with no access, `ack_n_o` and `tea_n_o` are 1 and `reg_req_o` is 0.
- R2: An access starts when chip select is seen active in the idle state. `reg_req_o` then rises and, while it stays high, `reg_addr_o`, `reg_we_o` (1 = write, the inverse of `rd_i`) and `reg_wdata_o` hold the values captured at the start.
- R3: When `reg_ack_i` is high in a cycle with `reg_req_o` high, `reg_req_o` falls and `ack_n_o` is 0 for exactly the next cycle. On a read, `rdata_o` then holds the `reg_rdata_i` value. `rpar_o[k]` is the odd parity of byte k (bits 8k+7..8k): it is 1 when that byte has an even number of ones.
- R4: If `reg_ack_i` stays low for TIMEOUT (32) consecutive cycles with `reg_req_o` high, `reg_req_o` falls and `tea_n_o` is 0 for exactly one cycle, with no `ack_n_o` pulse for that access.
- R5: An acknowledgment in the last (32nd) request cycle still completes the access normally, with `ack_n_o` low and no `tea_n_o` pulse.
- R6: For a write whose `wpar_i[k]` differs from the odd parity of data byte k, under any mode other than 2'b11, `tea_n_o` pulses low for one cycle in place of forwarding. `reg_req_o` stays 0 and no `ack_n_o` pulse is given.
- R7: With `mode_i` = 2'b11, a write parity mismatch is ignored. The write is forwarded and acknowledged normally.
- R8: A `reg_ack_i` that arrives after a timeout has ended the access produces no `ack_n_o` pulse.
- R9: `mode_i[0]` = 0 samples `cs_n_i` directly, and `reg_req_o` is high one cycle after the edge that sees it low. `mode_i[0]` = 1 passes `cs_n_i` through a two-flop synchronizer, which delays `reg_req_o` by two further cycles.
- R10: Each chip-select assertion gives at most one access. After completion no new request starts until chip select has been released.
- R11: `ack_n_o` and `tea_n_o` are never low together, and each low pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Bit 0: asynchronous chip-select sampling; 2'b11 also disables parity errors |
| cs_n_i | input | 1 | Active-low chip select |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 13 | Processor address |
| wdata_i | input | 16 | Processor write data |
| wpar_i | input | 2 | Processor write parity, one bit per byte |
| rdata_o | output | 16 | Read data to the processor |
| rpar_o | output | 2 | Generated odd parity of `rdata_o`, one bit per byte |
| ack_n_o | output | 1 | Active-low normal transfer acknowledge pulse |
| tea_n_o | output | 1 | Active-low transfer error pulse |
| reg_req_o | output | 1 | Request to the internal register port |
| reg_we_o | output | 1 | Internal write enable |
| reg_addr_o | output | 13 | Internal register address |
| reg_wdata_o | output | 16 | Internal write data |
| reg_rdata_i | input | 16 | Internal read data |
| reg_ack_i | input | 1 | Internal data acknowledgment |

## Verification
The bench builds the block with its default parameters: a 13-bit address, a 16-bit data bus and a 32-cycle timeout. With these values both sides of the watchdog boundary can be reached directly, an acknowledgment in request cycle 31 and one never given, each within a few dozen clocks. The two-stage synchronizer default gives a fixed and observable two-cycle latency difference between the sampling modes. Two parity lanes allow a single-lane mismatch in either byte to be driven.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } acc_state_t;

  localparam logic [1:0] MODE_NO_PARITY_ERR = 2'b11;

endpackage

// File: rtl/pbus_cs_sync.sv
module pbus_cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  output logic sel_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign chain_d[i] = sel_i;
      end else begin : g_next
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sel_o = chain_q[STAGES-1];

endmodule

// File: rtl/pbus_parity.sv
module pbus_parity #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   data_i,
  output logic [DW/8-1:0] par_o
);

  localparam int LANES = DW / 8;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign par_o[k] = ~(^data_i[8*k +: 8]);
    end
  endgenerate

endmodule

// File: rtl/pbus_watchdog.sv
module pbus_watchdog #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] SAT = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != SAT) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = run_i && (cnt_q == SAT);

endmodule

// File: rtl/pbus_slave.sv
module pbus_slave
  import pbus_pkg::*;
#(
  parameter int AW          = 13,
  parameter int DW          = 16,
  parameter int TIMEOUT     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic            cs_n_i,
  input  logic            rd_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [DW/8-1:0] wpar_i,
  output logic [DW-1:0]   rdata_o,
  output logic [DW/8-1:0] rpar_o,
  output logic            ack_n_o,
  output logic            tea_n_o,
  output logic            reg_req_o,
  output logic            reg_we_o,
  output logic [AW-1:0]   reg_addr_o,
  output logic [DW-1:0]   reg_wdata_o,
  input  logic [DW-1:0]   reg_rdata_i,
  input  logic            reg_ack_i
);

  localparam int PW = DW / 8;

  acc_state_t    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic [PW-1:0] rpar_q;
  logic          ack_n_q, ack_n_d;
  logic          tea_n_q, tea_n_d;
  logic          load_cmd, load_rd;

  logic          cs_synced;
  logic          cs_act;
  logic          async_mode;
  logic          par_err_en;
  logic [PW-1:0] wpar_calc;
  logic [PW-1:0] rpar_calc;
  logic          wpar_bad;
  logic          tmo;

  pbus_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sel_i (~cs_n_i),
    .sel_o (cs_synced)
  );

  pbus_parity #(.DW(DW)) u_wpar (
    .data_i (wdata_i),
    .par_o  (wpar_calc)
  );

  pbus_parity #(.DW(DW)) u_rpar (
    .data_i (reg_rdata_i),
    .par_o  (rpar_calc)
  );

  pbus_watchdog #(.LIMIT(TIMEOUT)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (state_q == ST_WAIT),
    .expired_o (tmo)
  );

  assign async_mode = mode_i[0];
  assign par_err_en = (mode_i != MODE_NO_PARITY_ERR);
  assign cs_act     = async_mode ? cs_synced : ~cs_n_i;
  assign wpar_bad   = |(wpar_i ^ wpar_calc);

  always_comb begin
    state_d  = state_q;
    ack_n_d  = 1'b1;
    tea_n_d  = 1'b1;
    load_cmd = 1'b0;
    load_rd  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cs_act) begin
          if (!rd_i && wpar_bad && par_err_en) begin
            tea_n_d = 1'b0;
            state_d = ST_DONE;
          end else begin
            load_cmd = 1'b1;
            state_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (reg_ack_i) begin
          ack_n_d = 1'b0;
          load_rd = ~we_q;
          state_d = ST_DONE;
        end else if (tmo) begin
          tea_n_d = 1'b0;
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        if (!cs_act) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_n_q <= 1'b1;
      tea_n_q <= 1'b1;
    end else begin
      state_q <= state_d;
      ack_n_q <= ack_n_d;
      tea_n_q <= tea_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load_cmd) begin
      addr_q  <= addr_i;
      we_q    <= ~rd_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rpar_q  <= '0;
    end else if (load_rd) begin
      rdata_q <= reg_rdata_i;
      rpar_q  <= rpar_calc;
    end
  end

  assign reg_req_o   = (state_q == ST_WAIT);
  assign reg_we_o    = we_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign rdata_o     = rdata_q;
  assign rpar_o      = rpar_q;
  assign ack_n_o     = ack_n_q;
  assign tea_n_o     = tea_n_q;

endmodule

// File: rtl/pbus_slave_chk.sv
module pbus_slave_chk #(
  parameter int AW      = 13,
  parameter int TIMEOUT = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_n_o,
  input logic          tea_n_o,
  input logic          reg_req_o,
  input logic          reg_ack_i,
  input logic [AW-1:0] reg_addr_o
);

  int unsigned req_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_run_q <= 0;
    else if (reg_req_o) req_run_q <= req_run_q + 1;
    else                req_run_q <= 0;
  end

  AST_ERR_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ack_n_o && !tea_n_o));                                             // R11

  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n_o |=> ack_n_o);                                                // R11

  AST_TEA_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tea_n_o |=> tea_n_o);                                                // R4

  AST_ACK_FROM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n_o) |-> $past(reg_req_o && reg_ack_i));                    // R3

  AST_REQ_ENDS_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_o && reg_ack_i) |=> !reg_req_o);                             // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_o && $past(reg_req_o)) |-> $stable(reg_addr_o));             // R2

  AST_REQ_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_o |-> (req_run_q < TIMEOUT));                                 // R4

endmodule

bind pbus_slave pbus_slave_chk #(.AW(AW), .TIMEOUT(TIMEOUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ack_n_o    (ack_n_o),
  .tea_n_o    (tea_n_o),
  .reg_req_o  (reg_req_o),
  .reg_ack_i  (reg_ack_i),
  .reg_addr_o (reg_addr_o)
);

// File: tb/tb_pbus_slave.sv
module tb_pbus_slave;

  logic        clk;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic        cs_n_i;
  logic        rd_i;
  logic [12:0] addr_i;
  logic [15:0] wdata_i;
  logic [1:0]  wpar_i;
  logic [15:0] rdata_o;
  logic [1:0]  rpar_o;
  logic        ack_n_o;
  logic        tea_n_o;
  logic        reg_req_o;
  logic        reg_we_o;
  logic [12:0] reg_addr_o;
  logic [15:0] reg_wdata_o;
  logic [15:0] reg_rdata_i;
  logic        reg_ack_i;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;
  int cycles   = 0;

  typedef struct {
    bit          is_tea;
    bit          chk_data;
    logic [15:0] data;
    logic [1:0]  par;
    string       tag;
  } exp_t;

  exp_t sb[$];

  pbus_slave dut (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .cs_n_i (cs_n_i),
    .rd_i (rd_i), .addr_i (addr_i), .wdata_i (wdata_i), .wpar_i (wpar_i),
    .rdata_o (rdata_o), .rpar_o (rpar_o), .ack_n_o (ack_n_o), .tea_n_o (tea_n_o),
    .reg_req_o (reg_req_o), .reg_we_o (reg_we_o), .reg_addr_o (reg_addr_o),
    .reg_wdata_o (reg_wdata_o), .reg_rdata_i (reg_rdata_i), .reg_ack_i (reg_ack_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [1:0] oddpar(input logic [15:0] d);
    oddpar[0] = ~(^d[7:0]);
    oddpar[1] = ~(^d[15:8]);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pop expected completion on every pulse.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (!ack_n_o && !tea_n_o)
        check(1'b0, "R11 both pulses low", {ack_n_o, tea_n_o}, 2'b11);
      else if (!ack_n_o || !tea_n_o) begin
        if (sb.size() == 0)
          check(1'b0, "R8/R10 unexpected pulse", {ack_n_o, tea_n_o}, 2'b11);
        else begin
          exp_t e;
          e = sb.pop_front();
          check((!tea_n_o) == e.is_tea, {e.tag, " completion kind"},
                {ack_n_o, tea_n_o}, e.is_tea ? 2'b10 : 2'b01);
          if (e.chk_data && !e.is_tea) begin
            check(rdata_o == e.data, {e.tag, " rdata"}, rdata_o, e.data);
            check(rpar_o == e.par, "R3 read parity", rpar_o, e.par);
          end
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Driver: one processor access. dly = request cycles before acknowledging (>=32: none).
  task automatic access(input bit rd, input logic [12:0] a, input logic [15:0] d,
                        input logic [1:0] par, input logic [1:0] mode,
                        input int dly, input bit late, input logic [15:0] rdv,
                        input string tag);
    exp_t e;
    bit   pbad;
    int   n;
    int   lat;
    int   reqcnt;
    pbad = !rd && (par != oddpar(d)) && (mode != 2'b11);
    lat  = mode[0] ? 3 : 1;
    e.is_tea   = pbad || (dly >= 32);
    e.chk_data = rd;
    e.data     = rdv;
    e.par      = oddpar(rdv);
    e.tag      = tag;
    sb.push_back(e);

    @(negedge clk);
    mode_i = mode; rd_i = rd; addr_i = a; wdata_i = d; wpar_i = par; cs_n_i = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!reg_req_o && ack_n_o && tea_n_o && n < 10);

    if (pbad) begin
      check(!reg_req_o, "R6 no forward on parity error", reg_req_o, 0);
      check(!tea_n_o, "R6 tea on parity error", tea_n_o, 0);
    end else begin
      check(n == lat, "R9 request latency", n, lat);
      check(reg_addr_o == a && reg_we_o == !rd && (rd || reg_wdata_o == d),
            "R2 forwarded command", {reg_we_o, reg_addr_o}, {!rd, a});
      if (dly < 32) begin
        repeat (dly) @(negedge clk);
        check(reg_req_o, "R2 request held", reg_req_o, 1);
        reg_ack_i = 1'b1; reg_rdata_i = rdv;
        @(negedge clk);
        reg_ack_i = 1'b0; reg_rdata_i = 16'hxxxx;
        check(!reg_req_o, "R3 request drops on ack", reg_req_o, 0);
      end else begin
        reqcnt = 1;
        while (reg_req_o && reqcnt < 40) begin
          @(negedge clk);
          if (reg_req_o) reqcnt++;
        end
        check(reqcnt == 32, "R4 timeout window", reqcnt, 32);
        if (late) begin
          reg_ack_i = 1'b1; reg_rdata_i = 16'h1234;
          @(negedge clk);
          reg_ack_i = 1'b0;
          @(negedge clk);
          check(ack_n_o, "R8 late ack ignored", ack_n_o, 1);
        end
      end
    end
    repeat (4) begin
      @(negedge clk);
      check(!reg_req_o, "R10 no repeat while selected", reg_req_o, 0);
    end
    cs_n_i = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; mode_i = 2'b00; cs_n_i = 1'b1; rd_i = 1'b1; addr_i = '0;
    wdata_i = '0; wpar_i = '0; reg_rdata_i = '0; reg_ack_i = 1'b0;
    repeat (3) @(negedge clk);
    check(ack_n_o && tea_n_o && !reg_req_o, "R1 in reset",
          {ack_n_o, tea_n_o, reg_req_o}, 3'b110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ack_n_o && tea_n_o && !reg_req_o, "R1 after reset",
          {ack_n_o, tea_n_o, reg_req_o}, 3'b110);

    access(1, 13'h0010, 16'h0, 2'b00, 2'b00, 0, 0, 16'hA5F0, "R3 read sync");
    access(1, 13'h1FFF, 16'h0, 2'b00, 2'b00, 3, 0, 16'h0000, "R3 read zeros");
    access(1, 13'h0AAA, 16'h0, 2'b00, 2'b10, 1, 0, 16'hFFFF, "R3 read ones");
    access(1, 13'h0555, 16'h0, 2'b00, 2'b00, 2, 0, 16'h0180, "R3 read mixed");
    access(0, 13'h0123, 16'hBEEF, oddpar(16'hBEEF), 2'b00, 5, 0, 16'h0, "R2 write good parity");
    access(1, 13'h0042, 16'h0, 2'b00, 2'b00, 40, 0, 16'h0, "R4 timeout");
    access(1, 13'h0043, 16'h0, 2'b00, 2'b00, 31, 0, 16'h7E81, "R5 ack at last cycle");
    access(0, 13'h0044, 16'h1357, oddpar(16'h1357), 2'b00, 40, 1, 16'h0, "R8 write timeout late ack");
    access(0, 13'h0045, 16'h00F0, oddpar(16'h00F0) ^ 2'b01, 2'b00, 0, 0, 16'h0, "R6 low byte parity error");
    access(0, 13'h0046, 16'h8001, oddpar(16'h8001) ^ 2'b10, 2'b10, 0, 0, 16'h0, "R6 high byte parity error");
    access(0, 13'h0047, 16'h8001, oddpar(16'h8001) ^ 2'b11, 2'b01, 0, 0, 16'h0, "R6 async parity error");
    access(0, 13'h0048, 16'hC3C3, oddpar(16'hC3C3) ^ 2'b11, 2'b11, 2, 0, 16'h0, "R7 parity error masked");
    access(1, 13'h0049, 16'h0, 2'b00, 2'b01, 4, 0, 16'h6BD2, "R9 async read");
    access(1, 13'h004A, 16'h0, 2'b00, 2'b11, 0, 0, 16'h0F0E, "R9 async read mode 3");

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R11 all completions seen", sb.size(), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule